// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block follows a single transmit queue that runs under block acknowledgement. It holds a sliding window of up to 64 consecutive frame slots. The window starts at the queue's read index, which marks the oldest frame not yet acknowledged and not the next frame to send. For every slot in the window the block stores two bits: whether the frame has gone out and whether the peer has acknowledged it. Ring indices are 8 bits wide, so a frame's index is its start sequence number modulo 256.

Software first programs the start index, a window size and a frame limit. From then on the block names one frame at a time on `nx_idx`. That frame is either a retransmit of a frame whose sending failed or the next new frame taken from the ring. The consumer accepts the frame with `nx_take`. Failure reports (`fail_valid`) and block-ack bitmaps (`ba_valid`) update the slot bits in any order. The window start then slides forward past every leading slot that has been both sent and acknowledged. `win_avail` shows whether the window can accept another new frame.

The controller has three states:
- `ST_IDLE`: the state after reset. It moves to `ST_RUN` on `cfg_load`.
- `ST_RUN`: frames are offered. The controller moves to `ST_SLIDE` when the head slot is acknowledged.
- `ST_SLIDE`: the head advances one slot per cycle while the head slot is acknowledged. It returns to `ST_RUN` once the head slot is not acknowledged or the window is empty. A `cfg_load` in any state goes to `ST_RUN` with a fresh window.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset, `nx_valid`=0, `win_avail`=0 and `rd_idx`=0 until `cfg_load`. A `cfg_load` in any state empties the window and sets `rd_idx` and the next new index to `cfg_start`.
- R2: When no retransmit is pending, the offered frame is the next new ring index with `nx_retry`=0. The first new index is `cfg_start`, and each accepted new frame advances it by one.
- R3: The number of frames fetched into the window, counted from `rd_idx`, never exceeds the limit. The limit is `cfg_win`, capped at 64, and a value of 0 allows no frames. `win_avail`=1 exactly when the count is below the limit.
- R4: At most `cfg_flim` new frames are issued between two block-acks. Any `ba_valid` restarts this count.
- R5: No new frame is offered while the next new index equals `wr_idx` (the ring is empty).
- R6: On a block-ack, bit i of `ba_bitmap` acknowledges ring index `ba_ssn`+i (mod 256). A bit is applied only if that index lies among the frames already fetched into the window; other bits have no effect.
- R7: The window start `rd_idx` advances past every leading slot that is acknowledged and stops at the first slot that is not. Each slot's bits are cleared as it leaves.
- R8: A failure report for a fetched frame that has been sent and not acknowledged marks it for retransmit. Retransmits are offered with `nx_retry`=1, lowest offset from `rd_idx` first, and they take priority over new frames.
- R9: A failure report for an acknowledged frame, or for an index outside the fetched frames, has no effect.
- R10: All ring indices wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Start a fresh window with the cfg_* values |
| cfg_start | input | 8 | First ring index of the window |
| cfg_win | input | 7 | Window size, capped at 64 |
| cfg_flim | input | 7 | New frames allowed between block-acks |
| wr_idx | input | 8 | Ring write index; frames exist below it |
| nx_take | input | 1 | Consumer accepts the offered frame |
| fail_valid | input | 1 | Failure report strobe |
| fail_idx | input | 8 | Ring index of the failed frame |
| ba_valid | input | 1 | Block-ack strobe |
| ba_ssn | input | 8 | Ring index acknowledged by bitmap bit 0 |
| ba_bitmap | input | 64 | Acknowledgement bits |
| nx_valid | output | 1 | A frame is offered |
| nx_idx | output | 8 | Ring index of the offered frame |
| nx_retry | output | 1 | Offered frame is a retransmit |
| rd_idx | output | 8 | Window start |
| win_avail | output | 1 | Window has room for another new frame |

## Verification
The main sequence starts the window near index 255, so fills, retries and slides all cross the wrap. A window of four fills up and stops new frames. Two failures test lowest-offset-first retry order. The block-ack patterns include a partial bitmap that frees the head, a bitmap with a bit beyond the fetched frames, and an acknowledgement of a non-head slot that leaves `rd_idx` in place. Failure reports aimed at acknowledged or unfetched frames show that ignored events leave the offer unchanged. Separate runs separate the frame-limit stop from the window-limit stop and from an empty ring, and check a full 64-slot window and a window size of zero.

// File: rtl/ba_trk_pkg.sv
package ba_trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLIDE = 2'd2
    } trk_state_e;
endpackage

// File: rtl/ba_slot_store.sv
// Per-slot sent/acked status, indexed by the low bits of the ring index.
module ba_slot_store #(
    parameter int SLOTS = 64,
    parameter int IDX_W = 8,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] cnt,
    input  logic             take_v,
    input  logic [IDX_W-1:0] take_idx,
    input  logic             fail_v,
    input  logic [IDX_W-1:0] fail_idx,
    input  logic             ba_v,
    input  logic [IDX_W-1:0] ba_ssn,
    input  logic [SLOTS-1:0] ba_map,
    input  logic             pop,
    output logic [SLOTS-1:0] sent_o,
    output logic [SLOTS-1:0] acked_o
);
    localparam int LO = $clog2(SLOTS);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [LO-1:0]    rel;
        logic [IDX_W-1:0] ring;
        logic [IDX_W-1:0] ba_off;
        logic             in_win, ba_hit, fail_hit, take_hit, pop_hit;

        assign rel      = LO'(g) - head[LO-1:0];
        assign ring     = head + IDX_W'(rel);
        assign in_win   = CNT_W'(rel) < cnt;
        assign ba_off   = ring - ba_ssn;
        assign ba_hit   = ba_v && in_win && (ba_off < IDX_W'(SLOTS)) && ba_map[ba_off[LO-1:0]];
        assign fail_hit = fail_v && (fail_idx == ring) && in_win && sent_o[g] && !acked_o[g];
        assign take_hit = take_v && (take_idx[LO-1:0] == LO'(g));
        assign pop_hit  = pop && (head[LO-1:0] == LO'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sent_o[g]  <= 1'b0;
                acked_o[g] <= 1'b0;
            end else if (clr || pop_hit) begin
                sent_o[g]  <= 1'b0;
                acked_o[g] <= 1'b0;
            end else begin
                if (take_hit)      sent_o[g] <= 1'b1;
                else if (fail_hit) sent_o[g] <= 1'b0;
                if (ba_hit)        acked_o[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ba_retry_pick.sv
// Finds the lowest window offset holding a fetched, unsent, unacked frame.
module ba_retry_pick #(
    parameter int SLOTS = 64,
    parameter int IDX_W = 8,
    parameter int CNT_W = 7
) (
    input  logic [IDX_W-1:0]         head,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [SLOTS-1:0]         sent,
    input  logic [SLOTS-1:0]         acked,
    output logic                     found,
    output logic [$clog2(SLOTS)-1:0] off
);
    localparam int LO = $clog2(SLOTS);

    logic [LO-1:0] slot;

    always_comb begin
        found = 1'b0;
        off   = '0;
        slot  = '0;
        for (int j = SLOTS - 1; j >= 0; j--) begin
            slot = head[LO-1:0] + LO'(j);
            if ((CNT_W'(j) < cnt) && !sent[slot] && !acked[slot]) begin
                found = 1'b1;
                off   = LO'(j);
            end
        end
    end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
    import ba_trk_pkg::*;
#(
    parameter int SLOTS = 64,
    parameter int IDX_W = 8,
    parameter int CFG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [IDX_W-1:0] cfg_start,
    input  logic [CFG_W-1:0] cfg_win,
    input  logic [CFG_W-1:0] cfg_flim,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             nx_take,
    input  logic             fail_valid,
    input  logic [IDX_W-1:0] fail_idx,
    input  logic             ba_valid,
    input  logic [IDX_W-1:0] ba_ssn,
    input  logic [SLOTS-1:0] ba_bitmap,
    output logic             nx_valid,
    output logic [IDX_W-1:0] nx_idx,
    output logic             nx_retry,
    output logic [IDX_W-1:0] rd_idx,
    output logic             win_avail
);
    localparam int LO    = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    trk_state_e       state, state_n;
    logic [IDX_W-1:0] head, nxt_new;
    logic [CNT_W-1:0] win_lim, cnt;
    logic [CFG_W-1:0] flim, burst;
    logic [SLOTS-1:0] sent, acked;
    logic             found, head_done, new_ok, take_fire, take_new, pop;
    logic [LO-1:0]    off;

    assign cnt       = CNT_W'(nxt_new - head);
    assign head_done = (cnt != '0) && acked[head[LO-1:0]];
    assign take_fire = nx_take && nx_valid;
    assign take_new  = take_fire && !found;
    assign pop       = (state == ST_SLIDE) && head_done && !cfg_load;

    ba_slot_store #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_load),
        .head     (head),
        .cnt      (cnt),
        .take_v   (take_fire),
        .take_idx (nx_idx),
        .fail_v   (fail_valid),
        .fail_idx (fail_idx),
        .ba_v     (ba_valid),
        .ba_ssn   (ba_ssn),
        .ba_map   (ba_bitmap),
        .pop      (pop),
        .sent_o   (sent),
        .acked_o  (acked)
    );

    ba_retry_pick #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
        .head  (head),
        .cnt   (cnt),
        .sent  (sent),
        .acked (acked),
        .found (found),
        .off   (off)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (cfg_load) state_n = ST_RUN;
            ST_RUN:   if (cfg_load) state_n = ST_RUN;
                      else if (head_done) state_n = ST_SLIDE;
            ST_SLIDE: if (cfg_load || !head_done) state_n = ST_RUN;
            default:  state_n = ST_IDLE;
        endcase
    end

    // state register and window pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            head    <= '0;
            nxt_new <= '0;
            win_lim <= '0;
            flim    <= '0;
            burst   <= '0;
        end else begin
            state <= state_n;
            if (cfg_load) begin
                head    <= cfg_start;
                nxt_new <= cfg_start;
                win_lim <= (int'(cfg_win) > SLOTS) ? CNT_W'(SLOTS) : CNT_W'(cfg_win);
                flim    <= cfg_flim;
                burst   <= '0;
            end else begin
                if (pop)      head    <= head + 1'b1;
                if (take_new) nxt_new <= nxt_new + 1'b1;
                if (ba_valid)      burst <= '0;
                else if (take_new) burst <= burst + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        win_avail = (state != ST_IDLE) && (cnt < win_lim);
        new_ok    = win_avail && (nxt_new != wr_idx) && (burst < flim);
        nx_valid  = (state == ST_RUN) && !head_done && (found || new_ok);
        nx_retry  = found;
        nx_idx    = found ? head + IDX_W'(off) : nxt_new;
        rd_idx    = head;
    end
endmodule

// File: rtl/ba_window_tracker_chk.sv
module ba_window_tracker_chk #(
    parameter int SLOTS = 64,
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [IDX_W-1:0] cfg_start,
    input logic [IDX_W-1:0] wr_idx,
    input logic             nx_take,
    input logic             fail_valid,
    input logic             ba_valid,
    input logic             nx_valid,
    input logic [IDX_W-1:0] nx_idx,
    input logic             nx_retry,
    input logic [IDX_W-1:0] rd_idx,
    input logic             win_avail
);
    p_new_needs_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_valid && !nx_retry) |-> win_avail);

    p_retry_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_valid && nx_retry) |-> (IDX_W'(nx_idx - rd_idx) < IDX_W'(SLOTS)));

    p_head_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ((rd_idx == $past(rd_idx)) || (rd_idx == IDX_W'($past(rd_idx) + 1'b1))));

    p_cfg_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> ((rd_idx == $past(cfg_start)) && !nx_retry));

    p_offer_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_valid && !nx_take && !ba_valid && !fail_valid && !cfg_load)
        |=> (!$stable(wr_idx) || (nx_valid && $stable(nx_idx))));
endmodule

bind ba_window_tracker ba_window_tracker_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_start  (cfg_start),
    .wr_idx     (wr_idx),
    .nx_take    (nx_take),
    .fail_valid (fail_valid),
    .ba_valid   (ba_valid),
    .nx_valid   (nx_valid),
    .nx_idx     (nx_idx),
    .nx_retry   (nx_retry),
    .rd_idx     (rd_idx),
    .win_avail  (win_avail)
);

// File: tb/ba_window_tracker_test.sv
`timescale 1ns/1ps
module ba_window_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_start = '0;
    logic [6:0]  cfg_win = '0;
    logic [6:0]  cfg_flim = '0;
    logic [7:0]  wr_idx = 8'h10;
    logic        nx_take = 1'b0;
    logic        fail_valid = 1'b0;
    logic [7:0]  fail_idx = '0;
    logic        ba_valid = 1'b0;
    logic [7:0]  ba_ssn = '0;
    logic [63:0] ba_bitmap = '0;
    logic        nx_valid, nx_retry, win_avail;
    logic [7:0]  nx_idx, rd_idx;

    int checks = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ba_window_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start(cfg_start),
        .cfg_win(cfg_win), .cfg_flim(cfg_flim), .wr_idx(wr_idx), .nx_take(nx_take),
        .fail_valid(fail_valid), .fail_idx(fail_idx), .ba_valid(ba_valid),
        .ba_ssn(ba_ssn), .ba_bitmap(ba_bitmap), .nx_valid(nx_valid), .nx_idx(nx_idx),
        .nx_retry(nx_retry), .rd_idx(rd_idx), .win_avail(win_avail)
    );

    // op: 0 configure, 1 take, 2 failure, 3 block-ack
    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  a;
        logic [63:0] bm;
        logic        ev;
        logic [7:0]  eidx;
        logic        er;
        logic [7:0]  erd;
        logic        eav;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'hFC, 64'h0A04, 1'b1, 8'hFC, 1'b0, 8'hFC, 1'b1, 4'd1},  // R1 window 4, limit 10
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'hFD, 1'b0, 8'hFC, 1'b1, 4'd2},  // R2
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'hFE, 1'b0, 8'hFC, 1'b1, 4'd2},  // R2
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'hFF, 1'b0, 8'hFC, 1'b1, 4'd2},  // R2
        '{3'd1, 8'h00, 64'h0,    1'b0, 8'h00, 1'b0, 8'hFC, 1'b0, 4'd3},  // R3 window full
        '{3'd2, 8'hFD, 64'h0,    1'b1, 8'hFD, 1'b1, 8'hFC, 1'b0, 4'd8},  // R8
        '{3'd2, 8'hFF, 64'h0,    1'b1, 8'hFD, 1'b1, 8'hFC, 1'b0, 4'd8},  // R8 lowest first
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'hFF, 1'b1, 8'hFC, 1'b0, 4'd8},  // R8
        '{3'd3, 8'hFC, 64'h3,    1'b1, 8'hFF, 1'b1, 8'hFE, 1'b1, 4'd7},  // R7
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'h00, 1'b0, 8'hFE, 1'b1, 4'd10}, // R10 wrap
        '{3'd3, 8'hFE, 64'h21,   1'b1, 8'h00, 1'b0, 8'hFF, 1'b1, 4'd6},  // R6 bit5 unfetched
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'h01, 1'b0, 8'hFF, 1'b1, 4'd2},  // R2
        '{3'd3, 8'hFF, 64'h3,    1'b1, 8'h01, 1'b0, 8'h01, 1'b1, 4'd7},  // R7 across wrap
        '{3'd2, 8'h01, 64'h0,    1'b1, 8'h01, 1'b0, 8'h01, 1'b1, 4'd9},  // R9 unfetched
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'h02, 1'b0, 8'h01, 1'b1, 4'd2},  // R2
        '{3'd1, 8'h00, 64'h0,    1'b1, 8'h03, 1'b0, 8'h01, 1'b1, 4'd2},  // R2
        '{3'd3, 8'h02, 64'h1,    1'b1, 8'h03, 1'b0, 8'h01, 1'b1, 4'd6},  // R6 non-head ack
        '{3'd2, 8'h02, 64'h0,    1'b1, 8'h03, 1'b0, 8'h01, 1'b1, 4'd9},  // R9 acked frame
        '{3'd2, 8'h01, 64'h0,    1'b1, 8'h01, 1'b1, 8'h01, 1'b1, 4'd8},  // R8
        '{3'd3, 8'h01, 64'h1,    1'b1, 8'h03, 1'b0, 8'h03, 1'b1, 4'd7}   // R7, R6 bit5 stayed clear
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [63:0] bm);
        @(negedge clk);
        case (op)
            3'd0: begin cfg_load = 1'b1; cfg_start = a; cfg_win = bm[6:0]; cfg_flim = bm[14:8]; end
            3'd1: nx_take = 1'b1;
            3'd2: begin fail_valid = 1'b1; fail_idx = a; end
            default: begin ba_valid = 1'b1; ba_ssn = a; ba_bitmap = bm; end
        endcase
        @(negedge clk);
        cfg_load = 1'b0; nx_take = 1'b0; fail_valid = 1'b0; ba_valid = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks + 1, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset nx_valid", 32'(nx_valid), 32'd0);
        chk("R1 reset win_avail", 32'(win_avail), 32'd0);
        chk("R1 reset rd_idx", 32'(rd_idx), 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].op, VEC[i].a, VEC[i].bm);
            chk($sformatf("R%0d step %0d nx_valid", VEC[i].req, i), 32'(nx_valid), 32'(VEC[i].ev));
            if (VEC[i].ev) begin
                chk($sformatf("R%0d step %0d nx_idx", VEC[i].req, i), 32'(nx_idx), 32'(VEC[i].eidx));
                chk($sformatf("R%0d step %0d nx_retry", VEC[i].req, i), 32'(nx_retry), 32'(VEC[i].er));
            end
            chk($sformatf("R%0d step %0d rd_idx", VEC[i].req, i), 32'(rd_idx), 32'(VEC[i].erd));
            chk($sformatf("R%0d step %0d win_avail", VEC[i].req, i), 32'(win_avail), 32'(VEC[i].eav));
        end

        // R4: frame limit 3 stops new frames while the window still has room
        wr_idx = 8'h40;
        do_op(3'd0, 8'h10, 64'h0340);
        for (int k = 0; k < 3; k++) do_op(3'd1, 8'h00, 64'h0);
        chk("R4 limit reached nx_valid", 32'(nx_valid), 32'd0);
        chk("R4 limit reached win_avail", 32'(win_avail), 32'd1);
        do_op(3'd3, 8'h20, 64'h0);
        chk("R4 after block-ack nx_valid", 32'(nx_valid), 32'd1);
        chk("R4 after block-ack nx_idx", 32'(nx_idx), 32'h13);

        // R5: empty ring
        do_op(3'd0, 8'h40, 64'h0A08);
        chk("R5 empty ring nx_valid", 32'(nx_valid), 32'd0);
        chk("R5 empty ring win_avail", 32'(win_avail), 32'd1);
        @(negedge clk);
        wr_idx = 8'h42;
        repeat (3) @(negedge clk);
        chk("R5 ring filled nx_valid", 32'(nx_valid), 32'd1);
        chk("R5 ring filled nx_idx", 32'(nx_idx), 32'h40);

        // R3: window size 100 caps at 64
        wr_idx = 8'h7F;
        do_op(3'd0, 8'h80, 64'h7F64);
        for (int k = 0; k < 63; k++) do_op(3'd1, 8'h00, 64'h0);
        chk("R3 63 fetched win_avail", 32'(win_avail), 32'd1);
        chk("R3 63 fetched nx_idx", 32'(nx_idx), 32'hBF);
        do_op(3'd1, 8'h00, 64'h0);
        chk("R3 64 fetched win_avail", 32'(win_avail), 32'd0);
        chk("R3 64 fetched nx_valid", 32'(nx_valid), 32'd0);
        chk("R3 64 fetched rd_idx", 32'(rd_idx), 32'h80);

        // R3: window size zero allows nothing
        do_op(3'd0, 8'h20, 64'h0A00);
        chk("R3 zero window win_avail", 32'(win_avail), 32'd0);
        chk("R3 zero window nx_valid", 32'(nx_valid), 32'd0);
        chk("R1 reload rd_idx", 32'(rd_idx), 32'h20);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule